// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block evaluates integer expressions written in postfix form. A host streams commands into it, one per accepted cycle: push a 32-bit operand, or apply one of four binary operators (add, subtract, multiply, divide). Each operator takes the two uppermost stack entries, computes `second OP top`, and leaves the single result on top.

Only the uppermost `NREG` entries are held in flops. Anything deeper lives in a synchronous backing RAM that is addressed by a spill pointer. When a push arrives and the register window is already full, the oldest window entry is written out to the RAM. When an operator leaves the window one short of full while the RAM still holds entries, one entry is read back into the bottom of the window. Every other command makes no RAM access. During a spill or a fill the block drops `ready` for one cycle and ignores any command offered in that cycle. Counters report how many spills and fills have taken place. They allow a host to measure how much RAM traffic a given window size causes.

Error conditions raise a sticky flag and leave the stack as it was: an operator with fewer than two entries, a push with the RAM full, division by zero, and a reserved opcode.

Top module: `rcstack_eval`

## Requirements
- R1: After reset `ready`=1, `depth`=0, `tos`=0, `err`=0 and both counters are 0. `tos` reads 0 whenever the stack is empty.
- R2: A push (opcode 0) accepted while fewer than `NREG` entries are in the window completes with no busy cycle. `tos` then shows the pushed value, `depth` rises by one, and neither counter changes.
- R3: A push accepted while the window holds `NREG` entries and the RAM is not full drops `ready` for exactly one cycle. Afterwards `spill_count` has risen by one, `tos` is the pushed value and `depth` has risen by one.
- R4: The operators are add = 1, subtract = 2, multiply = 3 and divide = 4. Each computes `second OP top`, keeping the low 32 bits of the two's complement result. Division truncates toward zero, and the most negative value divided by -1 gives the most negative value.
- R5: An operator accepted while the RAM holds at least one entry drops `ready` for exactly one cycle. Afterwards `fill_count` has risen by one and `depth` has fallen by one.
- R6: An operator accepted while the RAM is empty completes with no busy cycle and leaves both counters unchanged.
- R7: Each of the following sets `err` and leaves `depth`, `tos` and both counters unchanged: an operator with `depth` < 2, a push with `depth` = `NREG`+`MEM_DEPTH`, a divide with `tos` = 0, and any opcode 5, 6 or 7.
- R8: Once set, `err` stays at 1 until reset, and later valid commands still execute normally.
- R9: A command presented while `ready` is 0 is ignored.
- R10: With `NREG`=2, the sequence `a b c * + a d c * + e - /` ends with 4 spills and 4 fills. With `NREG`=4 the same sequence makes no RAM access. Both give the correct quotient.
- R11: Last-in-first-out order and values are preserved across any mix of spills and fills, for arbitrary command streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Opcode: 0 push, 1 add, 2 subtract, 3 multiply, 4 divide, 5 to 7 reserved |
| cmd_data | input | DW | Operand for a push |
| ready | output | 1 | Block can accept a command this cycle |
| tos | output | DW | Current top-of-stack value, 0 when empty |
| depth | output | DEPTH_W | Total entries in window plus RAM |
| spill_count | output | CNT_W | Window-to-RAM stores so far, wrapping |
| fill_count | output | CNT_W | RAM-to-window fetches so far, wrapping |
| err | output | 1 | Sticky error flag |

## Verification
Two pairs of actions coincide in one cycle. In a spill cycle the RAM write of the oldest window entry, the shift of the window and the insertion of the pushed value all happen together. In a fill, the operator result is written while the RAM read is launched, and the fetched word lands one cycle later. The bench provokes both pairs with deep stacks, reached by directed sequences and by a seeded random command stream. It judges them by comparing `tos`, `depth`, the counters and the count of busy cycles after every command with a bench stack model. It also offers a push during a busy cycle and confirms that the model's expected stack, which ignores that push, still matches.

// File: rtl/rcstack_pkg.sv
package rcstack_pkg;
   typedef enum logic [2:0] {
      OP_PUSH = 3'd0,
      OP_ADD  = 3'd1,
      OP_SUB  = 3'd2,
      OP_MUL  = 3'd3,
      OP_DIV  = 3'd4
   } rc_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SPILL = 2'd1,
      ST_FILL  = 2'd2
   } rc_state_e;
endpackage

// File: rtl/rcstack_alu.sv
module rcstack_alu
   import rcstack_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [2:0]    op,
   input  logic [DW-1:0] lhs,
   input  logic [DW-1:0] rhs,
   output logic [DW-1:0] res,
   output logic          div_zero
);
   localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] ALL_ONES = '1;
   localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};

   logic [DW-1:0] safe_rhs;
   logic [DW-1:0] quot;

   // Divider guarded against zero and against the one overflowing quotient
   always_comb begin
      safe_rhs = (rhs == '0) ? ONE : rhs;
      if (lhs == MOST_NEG && rhs == ALL_ONES) begin
         quot = MOST_NEG;
      end else begin
         quot = $signed(lhs) / $signed(safe_rhs);
      end
   end

   always_comb begin
      div_zero = (op == OP_DIV) && (rhs == '0);
      case (op)
         OP_ADD:  res = lhs + rhs;
         OP_SUB:  res = lhs - rhs;
         OP_MUL:  res = lhs * rhs;
         OP_DIV:  res = quot;
         default: res = lhs;
      endcase
   end
endmodule

// File: rtl/rcstack_ram.sv
module rcstack_ram #(
   parameter int  DW    = 32,
   parameter int  DEPTH = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      if (re) begin
         rdata <= mem[raddr];
      end
   end
endmodule

// File: rtl/rcstack_window.sv
module rcstack_window #(
   parameter int  DW   = 32,
   parameter int  NREG = 2,
   localparam int WCW  = $clog2(NREG + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [DW-1:0]  din,
   input  logic           wr_en,
   input  logic [WCW-1:0] wr_idx,
   input  logic           shift_dn,
   input  logic           shift_up,
   input  logic           cnt_inc,
   input  logic           cnt_dec,
   output logic [WCW-1:0] cnt,
   output logic [DW-1:0]  top,
   output logic [DW-1:0]  second,
   output logic [DW-1:0]  bottom
);
   // Index 0 holds the oldest entry in the window; index cnt-1 the top.
   logic [NREG-1:0][DW-1:0] ent;

   for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
      logic [DW-1:0] from_above;
      logic [DW-1:0] from_below;

      if (gi == NREG - 1) begin : g_hi
         assign from_above = din;
      end else begin : g_lo
         assign from_above = ent[gi+1];
      end

      if (gi == 0) begin : g_base
         assign from_below = din;
      end else begin : g_rest
         assign from_below = ent[gi-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent[gi] <= '0;
         end else if (shift_up) begin
            ent[gi] <= from_below;
         end else if (shift_dn) begin
            ent[gi] <= from_above;
         end else if (wr_en && wr_idx == WCW'(gi)) begin
            ent[gi] <= din;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt_inc) begin
         cnt <= cnt + WCW'(1);
      end else if (cnt_dec) begin
         cnt <= cnt - WCW'(1);
      end
   end

   always_comb begin
      top    = '0;
      second = '0;
      for (int i = 0; i < NREG; i++) begin
         if (cnt == WCW'(i + 1)) top    = ent[i];
         if (cnt == WCW'(i + 2)) second = ent[i];
      end
      bottom = ent[0];
   end
endmodule

// File: rtl/rcstack_eval.sv
module rcstack_eval
   import rcstack_pkg::*;
#(
   parameter int  DW        = 32,
   parameter int  NREG      = 2,
   parameter int  MEM_DEPTH = 16,
   parameter int  CNT_W     = 16,
   localparam int DEPTH_W   = $clog2(NREG + MEM_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [DW-1:0]      cmd_data,
   output logic               ready,
   output logic [DW-1:0]      tos,
   output logic [DEPTH_W-1:0] depth,
   output logic [CNT_W-1:0]   spill_count,
   output logic [CNT_W-1:0]   fill_count,
   output logic               err
);
   localparam int WCW = $clog2(NREG + 1);
   localparam int MAW = $clog2(MEM_DEPTH);
   localparam int MCW = $clog2(MEM_DEPTH + 1);

   if (NREG < 2) begin : g_bad_nreg
      $error("rcstack_eval: NREG must be at least 2");
   end
   if (MEM_DEPTH < 2) begin : g_bad_mem
      $error("rcstack_eval: MEM_DEPTH must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("rcstack_eval: DW must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rcstack_eval: CNT_W must be at least 1");
   end

   rc_state_e        state_q, state_d;
   logic [DW-1:0]    pend_q;
   logic [MCW-1:0]   mcnt_q;
   logic [CNT_W-1:0] spill_q, fill_q;
   logic             err_q;

   logic [WCW-1:0]   win_cnt;
   logic [DW-1:0]    win_top, win_second, win_bottom, win_din;
   logic             wr_en, shift_dn, shift_up, cnt_inc, cnt_dec;
   logic [WCW-1:0]   wr_idx;

   logic             ram_we, ram_re;
   logic [MAW-1:0]   ram_waddr, ram_raddr;
   logic [DW-1:0]    ram_rdata;

   logic [DW-1:0]    alu_res;
   logic             alu_dz;

   logic             err_set, pend_ld, mcnt_inc, mcnt_dec;
   logic             win_full, mem_full, mem_any, is_arith;

   rcstack_window #(.DW(DW), .NREG(NREG)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (win_din),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .shift_dn (shift_dn),
      .shift_up (shift_up),
      .cnt_inc  (cnt_inc),
      .cnt_dec  (cnt_dec),
      .cnt      (win_cnt),
      .top      (win_top),
      .second   (win_second),
      .bottom   (win_bottom)
   );

   rcstack_ram #(.DW(DW), .DEPTH(MEM_DEPTH)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (win_bottom),
      .re    (ram_re),
      .raddr (ram_raddr),
      .rdata (ram_rdata)
   );

   rcstack_alu #(.DW(DW)) u_alu (
      .op       (cmd_op),
      .lhs      (win_second),
      .rhs      (win_top),
      .res      (alu_res),
      .div_zero (alu_dz)
   );

   assign win_full  = (win_cnt == WCW'(NREG));
   assign mem_full  = (mcnt_q == MCW'(MEM_DEPTH));
   assign mem_any   = (mcnt_q != '0);
   assign is_arith  = (cmd_op >= 3'(OP_ADD)) && (cmd_op <= 3'(OP_DIV));
   assign ram_waddr = mcnt_q[MAW-1:0];
   assign ram_raddr = MAW'(mcnt_q - MCW'(1));

   always_comb begin
      state_d  = state_q;
      wr_en    = 1'b0;
      wr_idx   = '0;
      shift_dn = 1'b0;
      shift_up = 1'b0;
      cnt_inc  = 1'b0;
      cnt_dec  = 1'b0;
      win_din  = cmd_data;
      ram_we   = 1'b0;
      ram_re   = 1'b0;
      err_set  = 1'b0;
      pend_ld  = 1'b0;
      mcnt_inc = 1'b0;
      mcnt_dec = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (cmd_valid) begin
               if (cmd_op == 3'(OP_PUSH)) begin
                  if (!win_full) begin
                     wr_en   = 1'b1;
                     wr_idx  = win_cnt;
                     cnt_inc = 1'b1;
                  end else if (mem_full) begin
                     err_set = 1'b1;
                  end else begin
                     pend_ld = 1'b1;
                     state_d = ST_SPILL;
                  end
               end else if (is_arith) begin
                  if (win_cnt < WCW'(2) || alu_dz) begin
                     err_set = 1'b1;
                  end else begin
                     wr_en   = 1'b1;
                     wr_idx  = win_cnt - WCW'(2);
                     win_din = alu_res;
                     cnt_dec = 1'b1;
                     if (mem_any) begin
                        ram_re  = 1'b1;
                        state_d = ST_FILL;
                     end
                  end
               end else begin
                  err_set = 1'b1;
               end
            end
         end
         ST_SPILL: begin
            ram_we   = 1'b1;
            shift_dn = 1'b1;
            win_din  = pend_q;
            mcnt_inc = 1'b1;
            state_d  = ST_IDLE;
         end
         ST_FILL: begin
            shift_up = 1'b1;
            cnt_inc  = 1'b1;
            win_din  = ram_rdata;
            mcnt_dec = 1'b1;
            state_d  = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         mcnt_q  <= '0;
         spill_q <= '0;
         fill_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (pend_ld) begin
            pend_q <= cmd_data;
         end
         if (mcnt_inc) begin
            mcnt_q  <= mcnt_q + MCW'(1);
            spill_q <= spill_q + CNT_W'(1);
         end
         if (mcnt_dec) begin
            mcnt_q <= mcnt_q - MCW'(1);
            fill_q <= fill_q + CNT_W'(1);
         end
         if (err_set) begin
            err_q <= 1'b1;
         end
      end
   end

   assign ready       = (state_q == ST_IDLE);
   assign tos         = win_top;
   assign depth       = DEPTH_W'(win_cnt) + DEPTH_W'(mcnt_q);
   assign spill_count = spill_q;
   assign fill_count  = fill_q;
   assign err         = err_q;
endmodule

// File: rtl/rcstack_chk.sv
module rcstack_chk #(
   parameter int DW        = 32,
   parameter int NREG      = 2,
   parameter int MEM_DEPTH = 16,
   parameter int CNT_W     = 16,
   parameter int DEPTH_W   = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic               ready,
   input logic [DW-1:0]      tos,
   input logic [DEPTH_W-1:0] depth,
   input logic [CNT_W-1:0]   spill_count,
   input logic [CNT_W-1:0]   fill_count,
   input logic               err
);
   // R3 / R5: any busy period lasts exactly one cycle
   a_r3_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> ready);

   // R8: the error flag never clears without reset
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R7: depth never exceeds window plus RAM capacity
   a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= DEPTH_W'(NREG + MEM_DEPTH));

   // R2 / R3: a spill is counted only at the end of a busy cycle, by one
   a_r3_spill_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spill_count) |-> (!$past(ready) && spill_count == $past(spill_count) + CNT_W'(1)));

   // R5 / R6: a fill is counted only at the end of a busy cycle, by one
   a_r5_fill_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fill_count) |-> (!$past(ready) && fill_count == $past(fill_count) + CNT_W'(1)));

   // R9: with no command and nothing in flight, visible state holds
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !cmd_valid) |=> ($stable(depth) && $stable(tos) && $stable(spill_count)
                                  && $stable(fill_count)));
endmodule

bind rcstack_eval rcstack_chk #(
   .DW(DW), .NREG(NREG), .MEM_DEPTH(MEM_DEPTH), .CNT_W(CNT_W), .DEPTH_W(DEPTH_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .ready(ready), .tos(tos),
   .depth(depth), .spill_count(spill_count), .fill_count(fill_count), .err(err)
);

// File: tb/rcstack_eval_bench.sv
module rcstack_eval_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NREG    = 2;
   localparam int MEMD    = 8;
   localparam int DEPTH_W = $clog2(NREG + MEMD + 1);
   localparam int DEPTH_W4 = $clog2(4 + MEMD + 1);
   localparam int CAP     = NREG + MEMD;

   localparam logic [2:0] C_PUSH = 3'd0;
   localparam logic [2:0] C_ADD  = 3'd1;
   localparam logic [2:0] C_SUB  = 3'd2;
   localparam logic [2:0] C_MUL  = 3'd3;
   localparam logic [2:0] C_DIV  = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, v4 = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [31:0] cmd_data = '0;

   logic ready, err, ready4, err4;
   logic [31:0] tos, tos4;
   logic [DEPTH_W-1:0] depth;
   logic [DEPTH_W4-1:0] depth4;
   logic [15:0] spill_count, fill_count, spill4, fill4;

   rcstack_eval #(.DW(32), .NREG(NREG), .MEM_DEPTH(MEMD), .CNT_W(16)) u_rcstack_eval (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .ready(ready), .tos(tos), .depth(depth), .spill_count(spill_count),
      .fill_count(fill_count), .err(err));

   rcstack_eval #(.DW(32), .NREG(4), .MEM_DEPTH(MEMD), .CNT_W(16)) u_rcstack_eval_w4 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(v4), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .ready(ready4), .tos(tos4), .depth(depth4), .spill_count(spill4),
      .fill_count(fill4), .err(err4));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   logic [31:0] stk [CAP];
   int  mdep, mspill, mfill;
   bit  merr;

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] calc(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
      case (op)
         C_ADD: return a + b;
         C_SUB: return a - b;
         C_MUL: return a * b;
         default: begin
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
            return 32'($signed(a) / $signed(b));
         end
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd_valid = 1'b0; v4 = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      mdep = 0; mspill = 0; mfill = 0; merr = 1'b0;
   endtask

   task automatic run_cmd(input string tag, input logic [2:0] op, input logic [31:0] d,
                          input bit poke);
      int busy, exp_busy;
      logic [31:0] exp_tos;
      exp_busy = 0;
      if (op == C_PUSH) begin
         if (mdep == CAP) merr = 1'b1;
         else begin
            if (mdep >= NREG) begin mspill++; exp_busy = 1; end
            stk[mdep] = d; mdep++;
         end
      end else if (op >= C_ADD && op <= C_DIV) begin
         if (mdep < 2 || (op == C_DIV && stk[mdep-1] == 0)) merr = 1'b1;
         else begin
            if (mdep > NREG) begin mfill++; exp_busy = 1; end
            stk[mdep-2] = calc(op, stk[mdep-2], stk[mdep-1]);
            mdep--;
         end
      end else begin
         merr = 1'b1;
      end
      exp_tos = (mdep == 0) ? 32'd0 : stk[mdep-1];

      @(negedge clk);
      while (!ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      busy = 0;
      while (!ready && busy < 10) begin
         if (poke && busy == 0) begin
            cmd_valid = 1'b1; cmd_op = C_PUSH; cmd_data = 32'hDEAD_BEEF;
         end
         @(negedge clk);
         cmd_valid = 1'b0;
         busy++;
      end
      chk(tag, "busy cycles", 32'(busy), 32'(exp_busy));
      chk(tag, "tos", tos, exp_tos);
      chk(tag, "depth", 32'(depth), 32'(mdep));
      chk(tag, "err", 32'(err), 32'(merr));
      chk(tag, "spill_count", 32'(spill_count), 32'(mspill));
      chk(tag, "fill_count", 32'(fill_count), 32'(mfill));
   endtask

   task automatic run_w4(input logic [2:0] op, input logic [31:0] d);
      @(negedge clk);
      while (!ready4) @(negedge clk);
      v4 = 1'b1; cmd_op = op; cmd_data = d;
      @(negedge clk);
      v4 = 1'b0;
      while (!ready4) @(negedge clk);
   endtask

   function automatic logic [31:0] sv(input int x);
      return 32'(x);
   endfunction

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [2:0]  xo [13];
      logic [31:0] xd [13];
      void'($urandom(32'h5EED_0042));
      mdep = 0; mspill = 0; mfill = 0; merr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1", "ready", 32'(ready), 32'd1);
      chk("R1", "depth", 32'(depth), 32'd0);
      chk("R1", "tos", tos, 32'd0);
      chk("R1", "err", 32'(err), 32'd0);
      chk("R1", "spill_count", 32'(spill_count), 32'd0);
      chk("R1", "fill_count", 32'(fill_count), 32'd0);

      // R2, R3, R9, R5, R6 directed
      run_cmd("R2", C_PUSH, sv(7), 1'b0);
      run_cmd("R2", C_PUSH, sv(-3), 1'b0);
      run_cmd("R3", C_PUSH, sv(5), 1'b1);   // R9: push offered in busy cycle
      chk("R9", "depth after ignored push", 32'(depth), 32'd3);
      run_cmd("R5", C_MUL, 32'd0, 1'b1);    // R9 again during fill
      chk("R5", "product on top", tos, sv(-15));
      run_cmd("R6", C_ADD, 32'd0, 1'b0);
      chk("R6", "sum", tos, sv(-8));

      // R4: arithmetic corners
      run_cmd("R4", C_PUSH, sv(-7), 1'b0);
      run_cmd("R4", C_PUSH, sv(2), 1'b0);
      run_cmd("R4", C_DIV, 32'd0, 1'b0);
      chk("R4", "-7/2 truncates", tos, sv(-3));
      run_cmd("R4", C_SUB, 32'd0, 1'b0);
      chk("R4", "-8 - -3", tos, sv(-5));
      run_cmd("R4", C_PUSH, 32'h8000_0000, 1'b0);
      run_cmd("R4", C_PUSH, 32'hFFFF_FFFF, 1'b0);
      run_cmd("R4", C_DIV, 32'd0, 1'b0);
      chk("R4", "min / -1", tos, 32'h8000_0000);
      run_cmd("R4", C_PUSH, 32'h0001_0000, 1'b0);
      run_cmd("R4", C_PUSH, 32'h0001_0003, 1'b0);
      run_cmd("R4", C_MUL, 32'd0, 1'b0);
      chk("R4", "product wraps", tos, 32'h0003_0000);

      // R7 / R8: error cases
      do_reset();
      run_cmd("R7", C_ADD, 32'd0, 1'b0);
      chk("R7", "op on empty sets err", 32'(err), 32'd1);
      do_reset();
      run_cmd("R7", C_PUSH, sv(9), 1'b0);
      run_cmd("R7", C_PUSH, sv(0), 1'b0);
      run_cmd("R7", C_DIV, 32'd0, 1'b0);
      chk("R7", "div by zero keeps top", tos, 32'd0);
      run_cmd("R7", 3'd6, 32'd0, 1'b0);
      do_reset();
      for (int i = 0; i < CAP; i++) run_cmd("R3", C_PUSH, sv(100 + i), 1'b0);
      chk("R7", "err clear before overflow", 32'(err), 32'd0);
      run_cmd("R7", C_PUSH, sv(555), 1'b0);
      chk("R7", "full push refused", 32'(depth), 32'(CAP));
      run_cmd("R8", C_ADD, 32'd0, 1'b0);
      chk("R8", "err stays after good op", 32'(err), 32'd1);
      chk("R8", "op still executes", tos, sv(217));

      // R10: the reference expression on both window sizes
      xo = '{C_PUSH, C_PUSH, C_PUSH, C_MUL, C_ADD, C_PUSH, C_PUSH, C_PUSH, C_MUL, C_ADD,
             C_PUSH, C_SUB, C_DIV};
      xd = '{32'd100, 32'd3, 32'd4, 32'd0, 32'd0, 32'd100, 32'd2, 32'd4, 32'd0, 32'd0,
             32'd88, 32'd0, 32'd0};
      do_reset();
      for (int i = 0; i < 13; i++) run_cmd("R10", xo[i], xd[i], 1'b0);
      chk("R10", "N=2 spills", 32'(spill_count), 32'd4);
      chk("R10", "N=2 fills", 32'(fill_count), 32'd4);
      chk("R10", "N=2 quotient", tos, 32'd5);
      for (int i = 0; i < 13; i++) run_w4(xo[i], xd[i]);
      chk("R10", "N=4 spills", 32'(spill4), 32'd0);
      chk("R10", "N=4 fills", 32'(fill4), 32'd0);
      chk("R10", "N=4 quotient", tos4, 32'd5);
      chk("R10", "N=4 depth", 32'(depth4), 32'd1);
      chk("R10", "N=4 err", 32'(err4), 32'd0);

      // R11: seeded random streams
      for (int blk = 0; blk < 6; blk++) begin
         do_reset();
         for (int k = 0; k < 70; k++) begin
            int r;
            logic [2:0]  op;
            logic [31:0] d;
            r = int'($urandom % 100);
            if (r < 55) op = C_PUSH;
            else if (r < 97) op = 3'(1 + $urandom % 4);
            else op = 3'(5 + $urandom % 3);
            d = ($urandom % 3 == 0) ? 32'($signed(int'($urandom % 9)) - 4) : $urandom;
            run_cmd("R11", op, d, ($urandom % 4) == 0);
         end
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule